// File: doc/BRIEF.md
# Bunch-Crossing Hit Timestamp Capture

This block attaches a fine arrival time to each channel hit. A coarse counter counts bunch crossings, one step per crossing strobe, from the moment a spill-start pulse makes the block live. When a peak-found strobe arrives, the block latches the current crossing count. It then waits for the ramp window to close, which happens on the second crossing edge after the hit. Next it waits for the external time converter to report its 8-bit fine code. It then publishes a record made of the coarse count, the fine code and a combined timestamp.

The ramp and the converter sit outside this block. They appear only as a code bus and a done strobe. Hits are handled one at a time. A peak that arrives while a hit is still pending is dropped and counted.

The state machine has three states:
- `HS_IDLE`: no hit pending. An accepted peak moves it to `HS_RAMP`.
- `HS_RAMP`: the ramp window is open. The closing crossing edge moves it to `HS_CONVERT`.
- `HS_CONVERT`: waiting for the code. Converter done moves it back to `HS_IDLE`.

A spill start moves `HS_RAMP` or `HS_CONVERT` back to `HS_IDLE` and drops the pending hit.

Top module: `hit_timestamp_capture`

## Requirements
- R1: After reset `rec_valid` is low and `lost_hits` is zero.
- R2: Before the first `spill_start` the crossing count stays at zero and every `peak_found` is ignored: no record is made and `lost_hits` does not change. Once live, the count advances by one on each cycle with `xing_tick` high.
- R3: `spill_start` clears the crossing count to zero and takes priority over a `xing_tick` in the same cycle. A hit that is pending when it arrives is abandoned, so a later `fine_done` produces no record.
- R4: A `peak_found` accepted in `HS_IDLE` latches the count as it stood before any `xing_tick` of the same cycle.
- R5: The ramp window closes on the `xing_tick` that brings the count to the latched value plus 2 (modulo 4096). Only after that tick is the converter result accepted.
- R6: A `fine_done` that arrives while the window is still open is ignored. The first `fine_done` after the window closes writes the record. `rec_valid` is then high for exactly one cycle, the cycle after that strobe.
- R7: The record carries `rec_coarse` (the latched count), `rec_fine` (the code on `fine_code` with the accepted strobe) and `rec_time` = `rec_coarse`×256 + `rec_fine`×5. The unit of `rec_time` is 1/256 of a crossing period (25/256 ns), so one fine step equals five units and the fine ramp spans five crossings.
- R8: A `peak_found` while the state is not `HS_IDLE` increments `lost_hits` by one, which saturates at 255. The pending hit is otherwise unaffected.
- R9: The crossing count is 12 bits wide and wraps from 4095 to 0 without notice, including across the window close.
- R10: A `peak_found` in the cycle right after the accepted `fine_done` starts a new hit and is not counted as lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spill_start | input | 1 | Start-of-spill pulse; makes the block live and clears the count |
| xing_tick | input | 1 | One-cycle strobe marking a bunch-crossing rising edge |
| peak_found | input | 1 | One-cycle strobe from the channel peak detector |
| fine_done | input | 1 | One-cycle strobe: time converter result ready |
| fine_code | input | 8 | Fine time code from the converter |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_coarse | output | 12 | Latched crossing count of the hit |
| rec_fine | output | 8 | Fine code of the hit |
| rec_time | output | 21 | Combined time in 1/256 crossing units |
| lost_hits | output | 8 | Saturating count of dropped peaks |

## Verification
The assertions take each input strobe to be a single-cycle pulse that is sampled on the rising clock edge. They also take `spill_start` to be the only way the count is cleared. The checks on the lost-hit counter further assume that peaks do not coincide with a spill start while a hit is pending.

The stimulus drives every strobe on the falling edge for exactly one cycle. It keeps spill starts away from peaks and sends early `fine_done` strobes only to check that they are ignored. Expected records come from a bench-side crossing count that is advanced on every tick the bench issues.

// File: rtl/hts_pkg.sv
package hts_pkg;
    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_RAMP    = 2'd1,
        HS_CONVERT = 2'd2
    } hit_state_e;
endpackage

// File: rtl/hts_xing_counter.sv
module hts_xing_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spill_start,
    input  logic             xing_tick,
    output logic             live,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= 1'b0;
            count <= '0;
        end else if (spill_start) begin
            live  <= 1'b1;
            count <= '0;
        end else if (live && xing_tick) begin
            count <= count + CNT_W'(1);
        end
    end

    // R3: a spill start leaves the count at zero
    p_spill_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spill_start |=> (count == '0 && live));
    // R2: one step per crossing while live
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xing_tick && !spill_start) |=> count == $past(count) + CNT_W'(1));
    // R2: nothing moves before the spill
    p_dead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && !spill_start) |=> (count == '0));
endmodule

// File: rtl/hts_hit_fsm.sv
module hts_hit_fsm
    import hts_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int CODE_W      = 8,
    parameter int LOST_W      = 8,
    parameter int CLOSE_EDGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  logic              spill_start,
    input  logic              xing_tick,
    input  logic [CNT_W-1:0]  count,
    input  logic              peak_found,
    input  logic              fine_done,
    input  logic [CODE_W-1:0] fine_code,
    output logic              rec_valid,
    output logic [CNT_W-1:0]  rec_coarse,
    output logic [CODE_W-1:0] rec_fine,
    output logic [LOST_W-1:0] lost_hits
);
    localparam logic [LOST_W-1:0] LOST_MAX  = '1;
    localparam logic [CNT_W-1:0]  CLOSE_OFS = CNT_W'(CLOSE_EDGES - 1);

    hit_state_e       state, state_nxt;
    logic [CNT_W-1:0] lat_q;
    logic             accept, close_now, write_now;

    assign accept    = (state == HS_IDLE) && peak_found && live && !spill_start;
    assign close_now = (state == HS_RAMP) && !spill_start && xing_tick
                       && (count == lat_q + CLOSE_OFS);
    assign write_now = (state == HS_CONVERT) && !spill_start && fine_done;

    always_comb begin
        state_nxt = state;
        unique case (state)
            HS_IDLE:    if (accept) state_nxt = HS_RAMP;
            HS_RAMP: begin
                if (spill_start)    state_nxt = HS_IDLE;
                else if (close_now) state_nxt = HS_CONVERT;
            end
            HS_CONVERT: begin
                if (spill_start)    state_nxt = HS_IDLE;
                else if (write_now) state_nxt = HS_IDLE;
            end
            default:    state_nxt = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid  <= 1'b0;
            rec_coarse <= '0;
            rec_fine   <= '0;
            lat_q      <= '0;
            lost_hits  <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (accept) lat_q <= count;
            if (write_now) begin
                rec_valid  <= 1'b1;
                rec_coarse <= lat_q;
                rec_fine   <= fine_code;
            end
            if (state != HS_IDLE && peak_found && lost_hits != LOST_MAX)
                lost_hits <= lost_hits + LOST_W'(1);
        end
    end

    // R6: no record can come out of an open window
    p_early_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_RAMP) |=> !rec_valid);
    // R6: record strobe lasts one cycle
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);
    // R5: the window only closes on a crossing edge
    p_close_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_CONVERT && $past(state) == HS_RAMP) |-> $past(xing_tick));
    // R8: a peak while busy bumps the lost counter
    p_lost_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != HS_IDLE && peak_found && lost_hits != LOST_MAX)
        |=> lost_hits == $past(lost_hits) + LOST_W'(1));
    // R8: otherwise the lost counter holds
    p_lost_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_found |=> $stable(lost_hits));
    // R2: peaks before the spill never open a window
    p_no_hit_dead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && state == HS_IDLE) |=> state == HS_IDLE);
endmodule

// File: rtl/hts_time_merge.sv
module hts_time_merge #(
    parameter int CNT_W      = 12,
    parameter int CODE_W     = 8,
    parameter int RAMP_XINGS = 5
) (
    input  logic [CNT_W-1:0]      coarse,
    input  logic [CODE_W-1:0]     fine,
    output logic [CNT_W+CODE_W:0] stamp
);
    localparam int TW = CNT_W + CODE_W + 1;

    logic [TW-1:0] coarse_part, fine_part;

    assign coarse_part = TW'(coarse) << CODE_W;
    assign fine_part   = TW'(fine) * TW'(RAMP_XINGS);
    assign stamp       = coarse_part + fine_part;
endmodule

// File: rtl/hit_timestamp_capture.sv
module hit_timestamp_capture #(
    parameter int CNT_W       = 12,
    parameter int CODE_W      = 8,
    parameter int LOST_W      = 8,
    parameter int CLOSE_EDGES = 2,
    parameter int RAMP_XINGS  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spill_start,
    input  logic                  xing_tick,
    input  logic                  peak_found,
    input  logic                  fine_done,
    input  logic [CODE_W-1:0]     fine_code,
    output logic                  rec_valid,
    output logic [CNT_W-1:0]      rec_coarse,
    output logic [CODE_W-1:0]     rec_fine,
    output logic [CNT_W+CODE_W:0] rec_time,
    output logic [LOST_W-1:0]     lost_hits
);
    localparam int TW = CNT_W + CODE_W + 1;
    localparam logic [TW-1:0] FINE_SPAN = TW'(((1 << CODE_W) - 1) * RAMP_XINGS);

    logic             live;
    logic [CNT_W-1:0] count;

    hts_xing_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .spill_start (spill_start),
        .xing_tick   (xing_tick),
        .live        (live),
        .count       (count)
    );

    hts_hit_fsm #(
        .CNT_W(CNT_W), .CODE_W(CODE_W), .LOST_W(LOST_W), .CLOSE_EDGES(CLOSE_EDGES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .live        (live),
        .spill_start (spill_start),
        .xing_tick   (xing_tick),
        .count       (count),
        .peak_found  (peak_found),
        .fine_done   (fine_done),
        .fine_code   (fine_code),
        .rec_valid   (rec_valid),
        .rec_coarse  (rec_coarse),
        .rec_fine    (rec_fine),
        .lost_hits   (lost_hits)
    );

    hts_time_merge #(
        .CNT_W(CNT_W), .CODE_W(CODE_W), .RAMP_XINGS(RAMP_XINGS)
    ) u_merge (
        .coarse (rec_coarse),
        .fine   (rec_fine),
        .stamp  (rec_time)
    );

    // R7: the stamp sits inside the fine span above the coarse base
    p_stamp_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> ((rec_time - (TW'(rec_coarse) << CODE_W)) <= FINE_SPAN));
    // R1: nothing published in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rec_valid);
endmodule

// File: tb/hit_timestamp_capture_test.sv
module hit_timestamp_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spill_start = 1'b0;
    logic        xing_tick = 1'b0;
    logic        peak_found = 1'b0;
    logic        fine_done = 1'b0;
    logic [7:0]  fine_code = 8'd0;
    logic        rec_valid;
    logic [11:0] rec_coarse;
    logic [7:0]  rec_fine;
    logic [20:0] rec_time;
    logic [7:0]  lost_hits;

    int checks = 0;
    int fails  = 0;
    int bc     = 0;
    int exp_lost = 0;

    always #4 clk = ~clk;

    hit_timestamp_capture uut (
        .clk(clk), .rst_n(rst_n), .spill_start(spill_start), .xing_tick(xing_tick),
        .peak_found(peak_found), .fine_done(fine_done), .fine_code(fine_code),
        .rec_valid(rec_valid), .rec_coarse(rec_coarse), .rec_fine(rec_fine),
        .rec_time(rec_time), .lost_hits(lost_hits)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick();
        xing_tick = 1'b1;
        cyc();
        xing_tick = 1'b0;
        bc = (bc + 1) % 4096;
        cyc();
    endtask

    task automatic done_pulse(input logic [7:0] code);
        fine_done = 1'b1;
        fine_code = code;
        cyc();
        fine_done = 1'b0;
    endtask

    // full hit: peak (optionally on a crossing), optional early done, close, done, check
    task automatic run_hit(input logic [7:0] code, input bit on_tick, input bit early);
        int lat;
        lat = bc;
        peak_found = 1'b1;
        xing_tick  = on_tick;
        cyc();
        peak_found = 1'b0;
        xing_tick  = 1'b0;
        if (on_tick) bc = (bc + 1) % 4096;
        chk("R6 single pulse", rec_valid, 0);
        chk("R10 back-to-back not lost", lost_hits, exp_lost);
        if (early) begin
            done_pulse(~code);
            chk("R6 early done ignored", rec_valid, 0);
        end
        while (bc != (lat + 2) % 4096) tick();
        done_pulse(code);
        chk("R6 record strobe", rec_valid, 1);
        chk("R4 latched coarse", rec_coarse, lat);
        chk("R7 fine code", rec_fine, code);
        chk("R7 combined time", rec_time, longint'(lat) * 256 + longint'(code) * 5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 rec_valid reset", rec_valid, 0);
        chk("R1 lost reset", lost_hits, 0);

        // R2: before the spill, ticks and peaks do nothing
        xing_tick = 1'b1; cyc(); xing_tick = 1'b0; cyc();
        peak_found = 1'b1; cyc(); peak_found = 1'b0;
        xing_tick = 1'b1; cyc(); xing_tick = 1'b0; cyc();
        xing_tick = 1'b1; cyc(); xing_tick = 1'b0; cyc();
        done_pulse(8'd9);
        chk("R2 no record before spill", rec_valid, 0);
        chk("R2 no lost before spill", lost_hits, 0);

        // R3: spill start together with a tick: tick loses
        spill_start = 1'b1; xing_tick = 1'b1; cyc();
        spill_start = 1'b0; xing_tick = 1'b0; cyc();
        bc = 0;
        run_hit(8'd100, 1'b0, 1'b0);   // R2/R3: coarse starts at zero

        // exhaustive fine-code sweep, varying alignment, early done and spacing
        for (int i = 0; i < 256; i++) begin
            run_hit(8'(i), (i % 2) == 1, (i % 5) == 0);
            for (int k = 0; k < (i % 3); k++) tick();
        end

        // R8: peaks while pending, in the window and while converting
        begin
            int lat;
            lat = bc;
            peak_found = 1'b1; cyc(); peak_found = 1'b0;
            peak_found = 1'b1; cyc(); peak_found = 1'b0;
            peak_found = 1'b1; cyc(); peak_found = 1'b0;
            exp_lost += 2;
            cyc();
            chk("R8 lost in window", lost_hits, exp_lost);
            tick(); tick();
            peak_found = 1'b1; cyc(); peak_found = 1'b0;
            exp_lost += 1;
            cyc();
            chk("R8 lost while converting", lost_hits, exp_lost);
            done_pulse(8'd77);
            chk("R8 pending hit intact", rec_coarse, lat);
            chk("R8 pending hit time", rec_time, longint'(lat) * 256 + 77 * 5);
        end

        // R3: spill start abandons a pending hit
        peak_found = 1'b1; cyc(); peak_found = 1'b0;
        tick();
        spill_start = 1'b1; cyc(); spill_start = 1'b0; cyc();
        bc = 0;
        tick(); tick();
        done_pulse(8'd5);
        chk("R3 abandoned hit no record", rec_valid, 0);
        run_hit(8'd33, 1'b0, 1'b0);

        // R9: wrap of the crossing count across the window
        while (bc != 4095) tick();
        run_hit(8'd200, 1'b0, 1'b0);
        chk("R9 wrapped count after close", bc, 1);
        run_hit(8'd1, 1'b0, 1'b0);

        // R8: saturation
        peak_found = 1'b1; cyc(); peak_found = 1'b0;
        for (int k = 0; k < 300; k++) begin
            peak_found = 1'b1; cyc(); peak_found = 1'b0;
        end
        cyc();
        chk("R8 lost saturates", lost_hits, 255);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule